// File: doc/BRIEF.md
# Incremental Reciprocal Tracker

This block keeps a running fixed-point estimate of 1/n for a sample count n that advances by one with each new input sample. A downstream multiplier combines that estimate with an accumulated sum to form an average, so a division is never needed. The block has no table of reciprocals. Each time the count advances, it applies one Newton-Raphson refinement, r' = r·(2 − n·r), to the reciprocal it already holds. Because 1/(n−1) is already close to 1/n, one step per sample is enough once the count has grown past the first few values. The working range of the count is about 1 to 8000.

A step starts when the step strobe is high, the block reports ready, and the count input is nonzero. The first multiply forms the error term n·r into a register. The second multiply forms the corrected reciprocal, rounds it and registers it. The result therefore appears two clock edges after acceptance, with a one-cycle valid pulse. A count of 1 restarts the sequence by loading exactly 1.0. A count of 2 loads exactly 0.5. That second seed is needed because one refinement step from 1.0 at n = 2 lands on zero, and zero is a fixed point of the iteration.

Top module: `recip_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, recip_o is 0, recip_vld_o is 0 and ready_o is 1.
- R2: A step is accepted at a clock edge where step_i is 1, ready_o is 1 and count_i is nonzero. ready_o is 0 for exactly the one cycle after acceptance and is 1 again in the cycle that carries the result.
- R3: recip_vld_o is a one-cycle pulse. It is high in the second cycle after the accepting edge, and at no other time.
- R4: A step with count_i = 1 sets recip_o to exactly 8388608 (1.0 in unsigned Q1.23), whatever its previous value.
- R5: A step with count_i = 2 sets recip_o to exactly 4194304 (0.5 in Q1.23), with no refinement.
- R6: A step with count_i = n ≥ 3 and previous output r gives p = n·r and t = 2^24 − p, with t forced to 0 when p ≥ 2^24. The new output is floor((r·t + 2^22) / 2^23), limited to 2^24 − 1.
- R7: After a restart at 1 and unit increments up to n, for every n ≥ 300 the output lies within 1 LSB of 2^23/n.
- R8: A strobe with count_i = 0 is ignored. No pulse follows, ready_o stays 1 and recip_o keeps its value.
- R9: A strobe while ready_o is 0 is ignored. No extra result pulse is produced.
- R10: recip_o changes only in cycles where recip_vld_o is 1. After any step with count_i ≥ 2 it is at most 4194304.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Strobe: the count has advanced |
| count_i | input | 13 | Current sample count n, unsigned integer |
| ready_o | output | 1 | High when a new step can be accepted |
| recip_o | output | 24 | Reciprocal estimate, unsigned Q1.23 |
| recip_vld_o | output | 1 | One-cycle pulse when recip_o has been updated |

## Verification
A wrong held reciprocal appears at the ports in the very next result, two cycles after the following step is accepted. Because the refinement shrinks errors quadratically, a small corruption fades within a few further steps. For that reason the bench compares every output against an exact integer model of the recurrence on every clock, and does not rely only on the accuracy bound. A wrong busy or seed decision shows up one or two cycles after acceptance, as a misplaced ready or valid level or as a seed value that is not exactly 1.0 or 0.5. The full sweep from 1 to 8191 also checks the result against the true reciprocal, which exposes rounding or truncation faults that an exact model with the same fault would share.

// File: rtl/recip_pkg.sv
package recip_pkg;

    parameter int unsigned RT_CNT_W  = 13;
    parameter int unsigned RT_FRAC_W = 23;

    typedef enum logic [1:0] {
        K_RESTART = 2'd0,
        K_HALF    = 2'd1,
        K_REFINE  = 2'd2
    } step_kind_e;

    // Pick the update rule for a count value.
    function automatic step_kind_e classify(input int unsigned n);
        if (n == 1)      return K_RESTART;
        else if (n == 2) return K_HALF;
        else             return K_REFINE;
    endfunction

endpackage

// File: rtl/recip_ctrl.sv
module recip_ctrl
    import recip_pkg::*;
#(
    parameter int unsigned CNT_W = RT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             accept_o,
    output logic             finish_o,
    output logic             ready_o,
    output step_kind_e       kind_o
);

    logic busy_q;

    assign ready_o  = !busy_q;
    assign accept_o = step_i && !busy_q && (count_i != '0);
    assign finish_o = busy_q;
    assign kind_o   = classify(32'(count_i));

    // One step in flight at most; it completes on the edge after acceptance.
    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= accept_o;
    end

endmodule

// File: rtl/recip_err_stage.sv
module recip_err_stage
    import recip_pkg::*;
#(
    parameter int unsigned CNT_W  = RT_CNT_W,
    parameter int unsigned FRAC_W = RT_FRAC_W,
    localparam int unsigned R_W   = FRAC_W + 1,
    localparam int unsigned P_W   = CNT_W + R_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  step_kind_e       kind_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [R_W-1:0]   recip_i,
    output logic [P_W-1:0]   prod_o,
    output step_kind_e       kind_o
);

    logic [P_W-1:0] prod_d;

    // First multiply: n * r, kept at full width (integer part plus Q.23).
    assign prod_d = {{R_W{1'b0}}, count_i} * {{CNT_W{1'b0}}, recip_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_o <= '0;
            kind_o <= K_RESTART;
        end else if (accept_i) begin
            prod_o <= prod_d;
            kind_o <= kind_i;
        end
    end

endmodule

// File: rtl/recip_refine_stage.sv
module recip_refine_stage
    import recip_pkg::*;
#(
    parameter int unsigned CNT_W  = RT_CNT_W,
    parameter int unsigned FRAC_W = RT_FRAC_W,
    localparam int unsigned R_W   = FRAC_W + 1,
    localparam int unsigned P_W   = CNT_W + R_W,
    localparam int unsigned T_W   = FRAC_W + 2,
    localparam int unsigned M_W   = R_W + T_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           finish_i,
    input  step_kind_e     kind_i,
    input  logic [P_W-1:0] prod_i,
    output logic [R_W-1:0] recip_o,
    output logic           vld_o
);

    localparam logic [P_W-1:0] TWO_P   = P_W'(1) << (FRAC_W + 1);
    localparam logic [T_W-1:0] TWO_T   = T_W'(1) << (FRAC_W + 1);
    localparam logic [R_W-1:0] ONE_R   = R_W'(1) << FRAC_W;
    localparam logic [R_W-1:0] HALF_R  = R_W'(1) << (FRAC_W - 1);
    localparam logic [R_W-1:0] MAX_R   = {R_W{1'b1}};
    localparam logic [M_W-1:0] RND_M   = M_W'(1) << (FRAC_W - 1);
    localparam logic [M_W-1:0] MAX_M   = {{(M_W-R_W){1'b0}}, MAX_R};

    logic [T_W-1:0] corr;
    logic [M_W-1:0] mult;
    logic [M_W-1:0] scaled;
    logic [R_W-1:0] refined;
    logic [R_W-1:0] next_r;

    // Correction factor 2 - n*r in Q2.23; it cannot go below zero.
    assign corr    = (prod_i >= TWO_P) ? '0 : (TWO_T - prod_i[T_W-1:0]);
    // Second multiply: r * (2 - n*r), full width, then round half up to Q1.23.
    assign mult    = {{T_W{1'b0}}, recip_o} * {{R_W{1'b0}}, corr};
    assign scaled  = (mult + RND_M) >> FRAC_W;
    assign refined = (scaled > MAX_M) ? MAX_R : scaled[R_W-1:0];

    always_comb begin
        unique case (kind_i)
            K_RESTART: next_r = ONE_R;
            K_HALF:    next_r = HALF_R;
            default:   next_r = refined;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            recip_o <= '0;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= finish_i;
            if (finish_i) recip_o <= next_r;
        end
    end

endmodule

// File: rtl/recip_tracker.sv
module recip_tracker
    import recip_pkg::*;
#(
    parameter int unsigned CNT_W  = RT_CNT_W,
    parameter int unsigned FRAC_W = RT_FRAC_W,
    localparam int unsigned R_W   = FRAC_W + 1,
    localparam int unsigned P_W   = CNT_W + R_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             ready_o,
    output logic [R_W-1:0]   recip_o,
    output logic             recip_vld_o
);

    logic           accept;
    logic           finish;
    step_kind_e     kind_now;
    step_kind_e     kind_held;
    logic [P_W-1:0] err_prod;

    recip_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step_i),
        .count_i  (count_i),
        .accept_o (accept),
        .finish_o (finish),
        .ready_o  (ready_o),
        .kind_o   (kind_now)
    );

    recip_err_stage #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_err (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .kind_i   (kind_now),
        .count_i  (count_i),
        .recip_i  (recip_o),
        .prod_o   (err_prod),
        .kind_o   (kind_held)
    );

    recip_refine_stage #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_refine (
        .clk      (clk),
        .rst      (rst),
        .finish_i (finish),
        .kind_i   (kind_held),
        .prod_i   (err_prod),
        .recip_o  (recip_o),
        .vld_o    (recip_vld_o)
    );

endmodule

// File: rtl/recip_tracker_chk.sv
module recip_tracker_chk #(
    parameter int unsigned CNT_W  = 13,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned R_W   = FRAC_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             step_i,
    input logic [CNT_W-1:0] count_i,
    input logic             ready_o,
    input logic [R_W-1:0]   recip_o,
    input logic             recip_vld_o
);

    localparam logic [R_W-1:0] ONE_C  = R_W'(1) << FRAC_W;
    localparam logic [R_W-1:0] HALF_C = R_W'(1) << (FRAC_W - 1);

    logic taken;
    assign taken = step_i && ready_o && (count_i != '0);

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
        taken |=> !ready_o);

    assert_ready_returns_R2: assert property (@(posedge clk) disable iff (rst)
        !ready_o |=> ready_o);

    assert_result_latency_R3: assert property (@(posedge clk) disable iff (rst)
        taken |=> ##1 recip_vld_o);

    assert_pulse_origin_R3: assert property (@(posedge clk) disable iff (rst)
        recip_vld_o |-> $past(!ready_o));

    assert_restart_exact_R4: assert property (@(posedge clk) disable iff (rst)
        (taken && count_i == CNT_W'(1)) |=> ##1 (recip_o == ONE_C));

    assert_half_seed_R5: assert property (@(posedge clk) disable iff (rst)
        (taken && count_i == CNT_W'(2)) |=> ##1 (recip_o == HALF_C));

    assert_zero_count_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (step_i && ready_o && count_i == '0) |=> (ready_o && !recip_vld_o));

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (rst)
        !recip_vld_o |-> $stable(recip_o));

    assert_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        (taken && count_i >= CNT_W'(2)) |=> ##1 (recip_o <= HALF_C));

endmodule

bind recip_tracker recip_tracker_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step_i),
    .count_i     (count_i),
    .ready_o     (ready_o),
    .recip_o     (recip_o),
    .recip_vld_o (recip_vld_o)
);

// File: tb/recip_tracker_test.sv
`timescale 1ns/1ps
module recip_tracker_test;

    localparam int CW = 13;
    localparam int RW = 24;
    localparam longint ONE  = 64'd8388608;
    localparam longint HALF = 64'd4194304;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step = 1'b0;
    logic [CW-1:0] count = '0;
    logic          ready;
    logic [RW-1:0] recip;
    logic          vld;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    recip_tracker uut (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step),
        .count_i     (count),
        .ready_o     (ready),
        .recip_o     (recip),
        .recip_vld_o (vld)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural model of the recurrence, advanced on each rising edge.
    longint m_r = 0;
    longint m_n = 0;
    bit     m_busy = 0;
    bit     m_vld = 0;

    function automatic longint next_recip(input longint n, input longint r);
        longint p, t, q;
        if (n == 1) return ONE;
        if (n == 2) return HALF;
        p = n * r;
        t = (p >= 2 * ONE) ? 0 : 2 * ONE - p;
        q = (r * t + ONE / 2) / ONE;
        if (q > (1 << RW) - 1) q = (1 << RW) - 1;
        return q;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_r = 0; m_n = 0; m_busy = 0; m_vld = 0;
        end else begin
            m_vld = 0;
            if (m_busy) begin
                m_r = next_recip(m_n, m_r);
                m_vld = 1;
                m_busy = 0;
            end else if (step && count != 0) begin
                m_n = longint'(count);
                m_busy = 1;
            end
        end
    end

    // Compare every cycle against the model (R2 ready, R3 pulse, R6 value).
    always @(negedge clk) begin
        if (!rst) begin
            check(ready == !m_busy, "R2 ready", longint'(ready), longint'(!m_busy));
            check(vld == m_vld, "R3 valid", longint'(vld), longint'(m_vld));
            check(longint'(recip) == m_r, "R6 value", longint'(recip), m_r);
        end
    end

    task automatic do_step(input int n, output longint got);
        step = 1'b1; count = CW'(n);
        @(negedge clk);
        step = 1'b0;
        @(negedge clk);
        check(vld == 1'b1, "R3 latency", longint'(vld), 1);
        got = longint'(recip);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        longint got;
        int pulses;
        repeat (5) @(negedge clk);
        check(recip == '0, "R1 recip", longint'(recip), 0);
        check(vld == 1'b0, "R1 valid", longint'(vld), 0);
        check(ready == 1'b1, "R1 ready", longint'(ready), 1);
        rst = 1'b0;

        // Full sweep against the exact reciprocal.
        for (int n = 1; n <= 8191; n++) begin
            real exact, diff;
            do_step(n, got);
            if (n == 1) check(got == ONE, "R4 restart", got, ONE);
            else if (n == 2) check(got == HALF, "R5 half seed", got, HALF);
            else check(got <= HALF, "R10 bound", got, HALF);
            if (n >= 300) begin
                exact = 8388608.0 / n;
                diff = $itor(got) - exact;
                if (diff < 0.0) diff = -diff;
                check(diff <= 1.0, "R7 accuracy", got, longint'(exact));
            end
        end

        // Strobe held high: the strobe during the busy cycle is ignored (R9).
        pulses = 0;
        step = 1'b1; count = CW'(1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (vld) pulses++;
        end
        step = 1'b0;
        check(pulses == 2, "R9 busy strobe", pulses, 2);
        check(longint'(recip) == ONE, "R4 restart after sweep", longint'(recip), ONE);

        // Zero count is ignored (R8).
        @(negedge clk);
        step = 1'b1; count = '0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(vld == 1'b0, "R8 no pulse", longint'(vld), 0);
            check(ready == 1'b1, "R8 ready", longint'(ready), 1);
            check(longint'(recip) == ONE, "R8 held", longint'(recip), ONE);
        end
        step = 1'b0;
        @(negedge clk);

        // Jumping count drives the correction factor to its floor (R6).
        do_step(2, got);
        do_step(3, got);
        check(got == 64'd2097152, "R6 n=3 after half", got, 64'd2097152);
        do_step(10, got);
        check(got == 0, "R6 saturated correction", got, 0);
        repeat (3) @(negedge clk);
        check(got == longint'(recip), "R10 hold", longint'(recip), got);
        do_step(1, got);
        check(got == ONE, "R4 restart from zero", got, ONE);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule